// File: doc/BRIEF.md
# Segmented Byte Memory with Address Register

This block is the main memory of a small bus-oriented teaching processor. A byte is loaded from the shared data bus into an 8-bit address register. A segment bit from the control unit supplies the ninth address bit. Together they select one of 512 bytes, arranged as two 256-byte areas. The control unit keeps program code in segment 0 and data and stack in segment 1. Stores therefore never reach the code area.

The microcode drives three active-low strobes. One loads the address register. One reads the addressed byte onto the bus. One writes the bus byte into memory. The shared tri-state bus is modelled with split ports: an input byte, an output byte and an output-enable. The block enables its bus output only for a read.

A separate display output shows the byte at the current address at all times. It keeps doing so while the block is isolated from the bus, so a front panel can show memory contents. During a write, the display shows the byte arriving from the bus, because that byte is on the memory data lines.

Top module: `seg_ram`

## Requirements
- R1: On a rising clock edge with `addr_ld_n` low, the address register takes `bus_in`. With `addr_ld_n` high, it keeps its value. The register can never be read back onto the bus.
- R2: A segment register takes `seg_sel` on every rising clock edge. The effective address is {segment register, address register}, with the segment bit as the most significant bit. This gives 512 distinct bytes.
- R3: On a rising clock edge with `wr_n` low, `bus_in` is stored at the effective address. Writing a byte in one segment leaves the byte at the same 8-bit address in the other segment unchanged.
- R4: Holding `rd_n` and `wr_n` low in the same cycle is illegal.
- R5: `bus_oe` is 1 exactly when `rd_n` is low and `wr_n` is high. While `bus_oe` is 0, `bus_out` is 8'h00.
- R6: While `bus_oe` is 1, `bus_out` carries the byte stored at the effective address. It follows address changes without a clock.
- R7: While `wr_n` is high, `disp_out` shows the byte stored at the effective address, whatever `rd_n` is. While `wr_n` is low, it shows `bus_in`.
- R8: Reset is synchronous and active-low. A rising edge with `rst_n` low clears the address register and the segment register, and blocks any write. Memory contents are not cleared.
- R9: If a write and an address load fall on the same edge, the write goes to the address held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_sel | input | 1 | Segment select from the control unit (0 = code, 1 = data/stack) |
| addr_ld_n | input | 1 | Active-low address register load strobe |
| rd_n | input | 1 | Active-low memory read strobe |
| wr_n | input | 1 | Active-low memory write strobe |
| bus_in | input | 8 | Byte present on the shared data bus |
| bus_out | output | 8 | Byte the block drives onto the bus |
| bus_oe | output | 1 | Bus drive enable (high only during a read) |
| disp_out | output | 8 | Front-panel display byte |

## Verification
The bench builds the block with its default 8-bit address and 8-bit data widths. This configuration is small enough to sweep every one of the 512 locations. Each location in both segments gets its own arithmetically derived byte, so any aliasing between segments, and any dropped address bit, shows up as a mismatch. The same sweep checks the display output against every address in the idle state, and checks that the bus stays isolated around each read. Directed sequences then cover the combined write-and-load edge and a reset that arrives while the segment bit is set.

// File: rtl/seg_ram_pkg.sv
// Package: shared types for the segmented memory block.
// Assumes: one strobe at most is active per cycle (checked elsewhere).
package seg_ram_pkg;

    // Bus access state decoded from the microcode strobes
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_mode_t;

endpackage

// File: rtl/seg_ram_addr.sv
// Module: address register plus segment register.
// Loads the low address from the bus on an active-low strobe. Samples the
// segment bit every cycle. Both clear on a synchronous active-low reset.
// Assumes: the segment bit is settled one cycle before the access that needs it.
module seg_ram_addr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic [AW-1:0] ld_val,
    input  logic          seg_in,
    output logic [AW-1:0] addr_q,
    output logic          seg_q,
    output logic [AW:0]   eff_addr
);

    // Low address register: load on strobe, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (!ld_n)
            addr_q <= ld_val;
    end

    // Segment register: follows the control-unit bit every cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            seg_q <= 1'b0;
        else
            seg_q <= seg_in;
    end

    // Effective address: segment bit on top of the low address
    always_comb begin
        eff_addr = {seg_q, addr_q};
    end

endmodule

// File: rtl/seg_ram_ctl.sv
// Module: strobe decoder for the memory bus interface.
// Turns the active-low read and write strobes into a bus drive enable, a
// memory write enable and a memory output enable. It also reports a
// decoded access mode.
// Assumes: read and write strobes are never active together.
module seg_ram_ctl
    import seg_ram_pkg::*;
(
    input  logic      rst_n,
    input  logic      rd_n,
    input  logic      wr_n,
    output acc_mode_t mode,
    output logic      drive_en,
    output logic      mem_we,
    output logic      mem_oe
);

    // Decode the strobe pair into an access mode (write wins)
    always_comb begin
        if (!wr_n)
            mode = ACC_WRITE;
        else if (!rd_n)
            mode = ACC_READ;
        else
            mode = ACC_IDLE;
    end

    // Derive enables from the mode; writes are blocked during reset
    always_comb begin
        drive_en = (mode == ACC_READ);
        mem_we   = (mode == ACC_WRITE) && rst_n;
        mem_oe   = (mode != ACC_WRITE);
    end

endmodule

// File: rtl/seg_ram_store.sv
// Module: byte storage array, written on the clock edge, read asynchronously.
// Contents are not reset.
// Assumes: DEPTH is a power of two that matches the address width.
module seg_ram_store #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store the write byte on the rising edge when enabled
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    // Present the addressed byte without a clock
    always_comb begin
        rdata = mem[addr];
    end

endmodule

// File: rtl/seg_ram.sv
// Module: segmented byte memory with a bus-loaded address register.
// An AW-bit address register and a one-bit segment register select one of
// 2*(2**AW) bytes. The block drives the bus only on a read. The display
// port always shows the memory data lines.
// Assumes: the microcode never asserts read and write together.
module seg_ram
    import seg_ram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seg_sel,
    input  logic          addr_ld_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic [DW-1:0] disp_out
);

    localparam int FULL_AW = AW + 1;

    logic [AW-1:0]      addr_q;
    logic               seg_q;
    logic [FULL_AW-1:0] eff_addr;
    logic [DW-1:0]      mem_q;
    acc_mode_t          mode;
    logic               drive_en;
    logic               mem_we;
    logic               mem_oe;

    seg_ram_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_n     (addr_ld_n),
        .ld_val   (bus_in[AW-1:0]),
        .seg_in   (seg_sel),
        .addr_q   (addr_q),
        .seg_q    (seg_q),
        .eff_addr (eff_addr)
    );

    seg_ram_ctl u_ctl (
        .rst_n    (rst_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .mode     (mode),
        .drive_en (drive_en),
        .mem_we   (mem_we),
        .mem_oe   (mem_oe)
    );

    seg_ram_store #(.AW(FULL_AW), .DW(DW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .addr  (eff_addr),
        .wdata (bus_in),
        .rdata (mem_q)
    );

    // Bus side: memory byte on a read, quiet zero otherwise
    always_comb begin
        bus_oe  = drive_en;
        bus_out = drive_en ? mem_q : '0;
    end

    // Display side: memory data lines, carrying the bus byte during a write
    always_comb begin
        disp_out = mem_oe ? mem_q : bus_in;
    end

endmodule

// File: rtl/seg_ram_chk.sv
// Module: assertion checker for seg_ram, attached by bind.
// Assumes: it observes the top's ports and its address and memory read nets.
module seg_ram_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          seg_sel,
    input logic          addr_ld_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic [DW-1:0] bus_in,
    input logic [DW-1:0] bus_out,
    input logic          bus_oe,
    input logic [DW-1:0] disp_out,
    input logic [AW-1:0] addr_q,
    input logic          seg_q,
    input logic [DW-1:0] mem_q
);

    p_addr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !addr_ld_n) |=> (addr_q == $past(bus_in[AW-1:0])));

    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && addr_ld_n) |=> $stable(addr_q));

    p_seg_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (seg_q == $past(seg_sel)));

    p_no_dual_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_no_drive_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !bus_oe);

    p_quiet_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

    p_read_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_out == disp_out));

    p_write_display_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (disp_out == bus_in));

    p_idle_display_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |-> (disp_out == mem_q));

endmodule

bind seg_ram seg_ram_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_sel   (seg_sel),
    .addr_ld_n (addr_ld_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bus_in    (bus_in),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .disp_out  (disp_out),
    .addr_q    (addr_q),
    .seg_q     (seg_q),
    .mem_q     (mem_q)
);

// File: tb/seg_ram_test.sv
module seg_ram_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seg_sel = 1'b0;
    logic       addr_ld_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [7:0] disp_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_ram uut (
        .clk(clk), .rst_n(rst_n), .seg_sel(seg_sel), .addr_ld_n(addr_ld_n),
        .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .disp_out(disp_out)
    );

    function automatic logic [7:0] pat(input logic s, input int a);
        if (s) return 8'((a * 3 + 7) % 256);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Select address and segment; both registers update on the next edge
    task automatic point(input logic s, input logic [7:0] a);
        @(negedge clk);
        seg_sel = s; bus_in = a; addr_ld_n = 1'b0;
        @(negedge clk);
        addr_ld_n = 1'b1; bus_in = 8'hC3;
    endtask

    task automatic store(input logic [7:0] v);
        @(negedge clk);
        wr_n = 1'b0; bus_in = v;
        #1;
        check("R5 no drive on write", {7'd0, bus_oe}, 8'd0);
        check("R7 display during write", disp_out, v);
        @(negedge clk);
        wr_n = 1'b1; bus_in = 8'h3C;
    endtask

    task automatic fetch(input string req, input logic [7:0] exp);
        #1;
        check("R7 idle display", disp_out, exp);
        check("R5 idle bus", {bus_oe, bus_out[6:0]}, 8'd0);
        rd_n = 1'b0;
        #1;
        check("R5 read enables bus", {7'd0, bus_oe}, 8'd1);
        check(req, bus_out, exp);
        rd_n = 1'b1;
        #1;
        check("R5 bus released", bus_out, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 bus idle after reset", {7'd0, bus_oe}, 8'd0);

        // R2/R3 sweep: distinct bytes at every location of both segments
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 256; a++) begin
                point(s[0], 8'(a));
                store(pat(s[0], a));
            end

        // R1/R6/R3 readback: each segment keeps its own byte
        for (int a = 0; a < 256; a++)
            for (int s = 0; s < 2; s++) begin
                point(s[0], 8'(a));
                fetch("R6 R3 segment readback", pat(s[0], a));
            end

        // R6 read follows address changes without a clock: hold read low,
        // load a new address, check bus after the edge
        point(1'b0, 8'h20);
        @(negedge clk);
        rd_n = 1'b0; bus_in = 8'h21; addr_ld_n = 1'b0;
        #1 check("R6 before reload", bus_out, pat(1'b0, 8'h20));
        @(negedge clk);
        addr_ld_n = 1'b1;
        #1 check("R1 R6 after reload", bus_out, pat(1'b0, 8'h21));
        rd_n = 1'b1;

        // R9: write and address load on the same edge
        point(1'b1, 8'h10);
        @(negedge clk);
        wr_n = 1'b0; addr_ld_n = 1'b0; bus_in = 8'h33;
        @(negedge clk);
        wr_n = 1'b1; addr_ld_n = 1'b1;
        fetch("R9 R1 new address untouched", pat(1'b1, 8'h33));
        point(1'b1, 8'h10);
        fetch("R9 write used old address", 8'h33);
        point(1'b0, 8'h10);
        fetch("R3 other segment intact", pat(1'b0, 8'h10));

        // R8: reset with segment 1 selected clears both registers
        point(1'b1, 8'h77);
        @(negedge clk);
        rst_n = 1'b0; wr_n = 1'b0; bus_in = 8'h99;
        @(negedge clk);
        wr_n = 1'b1; rst_n = 1'b1; seg_sel = 1'b0;
        store(8'hEE);
        point(1'b0, 8'h00);
        fetch("R8 reset cleared address and segment", 8'hEE);
        point(1'b1, 8'h77);
        fetch("R8 write blocked in reset", pat(1'b1, 8'h77));

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule